// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

This block turns single burst requests into a DDR-style command stream on active-low chip-select, row strobe, column strobe and write-enable lines, along with bank and address buses. Each request names a direction, a bank, a row and a starting column. The block keeps one open-row entry per bank. A request to the row already open in its bank goes straight to the column command. A request to an idle bank first opens the row. A request that collides with a different open row first closes that row, then opens the new one.

Requests use a valid/ready handshake, and only one request is handled at a time. The timing from opening a row to the column command is a parameter in clock cycles. So is the timing from closing a row to reopening one. A configuration input picks a burst of 4 or 8 beats, and the burst length sets the minimum distance between column commands. Refresh, mode-register setup and the data path are handled elsewhere.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset (asynchronous, active low) all bank entries are closed, `req_ready` is 1, and the command lines show NOP with bank and address at 0. A reset in the middle of operation also closes every bank, so the next request to any bank starts with ACTIVE.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: ACTIVE = 0011, READ = 0101, WRITE = 0100, PRECHARGE = 0010, NOP = 0111. Every cycle after reset shows one of these five codes.
- R3: A request accepted at clock edge E to a bank with no open row issues ACTIVE in the cycle after E. It issues the column command T_RCD cycles after the ACTIVE.
- R4: A request accepted at edge E that targets the row already open in its bank issues its READ or WRITE in the cycle after E, with no ACTIVE.
- R5: A request accepted at edge E to a bank holding a different open row issues PRECHARGE to that bank (address 0) in the cycle after E. It issues ACTIVE T_RP cycles later and the column command T_RCD cycles after the ACTIVE.
- R6: ACTIVE carries the requested bank on the bank bus and the row, zero-extended, on the address bus. READ and WRITE carry the bank and the starting column, zero-extended. PRECHARGE carries the bank.
- R7: `cfg_burst8` = 0 selects a burst of 4 and = 1 selects a burst of 8. The value is sampled when the request is accepted. Two column commands are at least BL/2 cycles apart. When the next request is already waiting, they are exactly BL/2 cycles apart.
- R8: `req_ready` is 0 while a precharge or activate wait is in progress. It is also 0 in the cycles during which the column spacing of R7 has not yet elapsed.
- R9: Each of the 8 banks has its own open-row entry. Opening or closing a row in one bank leaves the other banks' hit/miss outcome unchanged.
- R10: A request held valid while `req_ready` is 0 is not accepted until ready returns. Each accepted request produces exactly one column command, and the cycle after an acceptance is never a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column of the burst |
| cfg_burst8 | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BANK_W | Bank address |
| dram_addr | output | max(ROW_W, COL_W) | Row or column address |

## Verification
The assertions assume that at most one request is in flight, so the time since the most recent ACTIVE or PRECHARGE of any bank bounds the gap before the next column command or ACTIVE. They also assume that request fields and `cfg_burst8` matter only at the accepting edge. The stimulus holds every request field and the burst select steady from the moment valid rises until the accepting edge. It drops valid one time step after that edge. It waits long enough after each vector for the wait timers to expire before the log is read. The spacing test is the only place where requests are chained back to back.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;

   // {ras_n, cas_n, we_n}; cs_n is always 0 once out of reset
   typedef enum logic [2:0] {
      OP_NOP = 3'b111,
      OP_ACT = 3'b011,
      OP_RD  = 3'b101,
      OP_WR  = 3'b100,
      OP_PRE = 3'b010
   } dcs_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE_WAIT,
      ST_ACT_WAIT
   } dcs_state_e;

   function automatic dcs_op_e col_op(input logic is_write);
      return is_write ? OP_WR : OP_RD;
   endfunction

endpackage

// File: rtl/dcs_row_table.sv
`timescale 1ns/1ps
module dcs_row_table #(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] lk_bank,
   input  logic [ROW_W-1:0]  lk_row,
   output logic              lk_open,
   output logic              lk_hit,
   input  logic [BANK_W-1:0] upd_bank,
   input  logic              close_en,
   input  logic              open_en,
   input  logic [ROW_W-1:0]  open_row
);
   localparam int NBANK = 1 << BANK_W;

   logic [NBANK-1:0]            open_vec;
   logic [NBANK-1:0][ROW_W-1:0] row_vec;

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic             v_q;
      logic [ROW_W-1:0] r_q;
      logic             sel;

      assign sel = (upd_bank == BANK_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            r_q <= '0;
         end else if (open_en && sel) begin
            v_q <= 1'b1;
            r_q <= open_row;
         end else if (close_en && sel) begin
            v_q <= 1'b0;
         end
      end

      assign open_vec[g] = v_q;
      assign row_vec[g]  = r_q;
   end

   assign lk_open = open_vec[lk_bank];
   assign lk_hit  = lk_open && (row_vec[lk_bank] == lk_row);

endmodule

// File: rtl/dcs_down_timer.sv
`timescale 1ns/1ps
module dcs_down_timer #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/dcs_cmd_reg.sv
`timescale 1ns/1ps
module dcs_cmd_reg
   import dcs_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dcs_op_e           op_d,
   input  logic [BANK_W-1:0] ba_d,
   input  logic [ADDR_W-1:0] addr_d,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr
);
   dcs_op_e op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= OP_NOP;
         ba   <= '0;
         addr <= '0;
      end else begin
         op_q <= op_d;
         ba   <= ba_d;
         addr <= addr_d;
      end
   end

   assign cs_n                 = 1'b0;
   assign {ras_n, cas_n, we_n} = op_q;

endmodule

// File: rtl/dram_cmd_seq.sv
`timescale 1ns/1ps
module dram_cmd_seq
   import dcs_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10,
   parameter int T_RCD  = 3,
   parameter int T_RP   = 3
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    req_valid,
   output logic                                    req_ready,
   input  logic                                    req_write,
   input  logic [BANK_W-1:0]                       req_bank,
   input  logic [ROW_W-1:0]                        req_row,
   input  logic [COL_W-1:0]                        req_col,
   input  logic                                    cfg_burst8,
   output logic                                    dram_cs_n,
   output logic                                    dram_ras_n,
   output logic                                    dram_cas_n,
   output logic                                    dram_we_n,
   output logic [BANK_W-1:0]                       dram_ba,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr
);
   localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int BL_SHORT  = 4;
   localparam int BL_LONG   = 8;
   localparam int GAP_SHORT = BL_SHORT / 2 - 1;
   localparam int GAP_LONG  = BL_LONG / 2 - 1;
   localparam int WAIT_MAX0 = (T_RP > T_RCD) ? T_RP : T_RCD;
   localparam int WAIT_MAX  = (WAIT_MAX0 > GAP_LONG) ? WAIT_MAX0 : GAP_LONG;
   localparam int TMR_W     = $clog2(WAIT_MAX + 1);

   localparam logic [TMR_W-1:0] GAP_S_V = TMR_W'(GAP_SHORT);
   localparam logic [TMR_W-1:0] GAP_L_V = TMR_W'(GAP_LONG);
   localparam logic [TMR_W-1:0] RP_V    = TMR_W'(T_RP - 1);
   localparam logic [TMR_W-1:0] RCD_V   = TMR_W'(T_RCD - 1);

   if (T_RCD < 1) begin : g_bad_rcd
      $error("T_RCD must be at least 1");
   end
   if (T_RP < 1) begin : g_bad_rp
      $error("T_RP must be at least 1");
   end
   if (BANK_W < 1 || ROW_W < 1 || COL_W < 1) begin : g_bad_w
      $error("address widths must be positive");
   end

   dcs_state_e state_q, state_d;

   logic              lt_write;
   logic              lt_b8;
   logic [BANK_W-1:0] lt_bank;
   logic [ROW_W-1:0]  lt_row;
   logic [COL_W-1:0]  lt_col;

   logic              accept;
   logic              lk_open, lk_hit;
   logic [BANK_W-1:0] tbl_bank;
   logic [ROW_W-1:0]  tbl_row;
   logic              close_en, open_en;

   logic              wt_load, wt_zero;
   logic [TMR_W-1:0]  wt_val;
   logic              gp_load, gp_zero;
   logic [TMR_W-1:0]  gp_val;

   dcs_op_e           op_d;
   logic [BANK_W-1:0] ba_d;
   logic [ADDR_W-1:0] addr_d;

   assign req_ready = (state_q == ST_IDLE) && gp_zero;
   assign accept    = req_valid && req_ready;

   dcs_row_table #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W)
   ) rows_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_bank  (req_bank),
      .lk_row   (req_row),
      .lk_open  (lk_open),
      .lk_hit   (lk_hit),
      .upd_bank (tbl_bank),
      .close_en (close_en),
      .open_en  (open_en),
      .open_row (tbl_row)
   );

   dcs_down_timer #(.W(TMR_W)) wait_tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wt_load),
      .load_val (wt_val),
      .zero     (wt_zero)
   );

   dcs_down_timer #(.W(TMR_W)) gap_tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gp_load),
      .load_val (gp_val),
      .zero     (gp_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         lt_write <= 1'b0;
         lt_b8    <= 1'b0;
         lt_bank  <= '0;
         lt_row   <= '0;
         lt_col   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            lt_write <= req_write;
            lt_b8    <= cfg_burst8;
            lt_bank  <= req_bank;
            lt_row   <= req_row;
            lt_col   <= req_col;
         end
      end
   end

   always_comb begin
      state_d  = state_q;
      op_d     = OP_NOP;
      ba_d     = '0;
      addr_d   = '0;
      wt_load  = 1'b0;
      wt_val   = '0;
      gp_load  = 1'b0;
      gp_val   = '0;
      close_en = 1'b0;
      open_en  = 1'b0;
      tbl_bank = lt_bank;
      tbl_row  = lt_row;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               tbl_bank = req_bank;
               tbl_row  = req_row;
               ba_d     = req_bank;
               if (lk_hit) begin
                  op_d    = col_op(req_write);
                  addr_d  = ADDR_W'(req_col);
                  gp_load = 1'b1;
                  gp_val  = cfg_burst8 ? GAP_L_V : GAP_S_V;
               end else if (lk_open) begin
                  op_d     = OP_PRE;
                  close_en = 1'b1;
                  wt_load  = 1'b1;
                  wt_val   = RP_V;
                  state_d  = ST_PRE_WAIT;
               end else begin
                  op_d    = OP_ACT;
                  addr_d  = ADDR_W'(req_row);
                  open_en = 1'b1;
                  wt_load = 1'b1;
                  wt_val  = RCD_V;
                  state_d = ST_ACT_WAIT;
               end
            end
         end
         ST_PRE_WAIT: begin
            if (wt_zero) begin
               op_d    = OP_ACT;
               ba_d    = lt_bank;
               addr_d  = ADDR_W'(lt_row);
               open_en = 1'b1;
               wt_load = 1'b1;
               wt_val  = RCD_V;
               state_d = ST_ACT_WAIT;
            end
         end
         ST_ACT_WAIT: begin
            if (wt_zero) begin
               op_d    = col_op(lt_write);
               ba_d    = lt_bank;
               addr_d  = ADDR_W'(lt_col);
               gp_load = 1'b1;
               gp_val  = lt_b8 ? GAP_L_V : GAP_S_V;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   dcs_cmd_reg #(
      .BANK_W (BANK_W),
      .ADDR_W (ADDR_W)
   ) cmd_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_d   (op_d),
      .ba_d   (ba_d),
      .addr_d (addr_d),
      .cs_n   (dram_cs_n),
      .ras_n  (dram_ras_n),
      .cas_n  (dram_cas_n),
      .we_n   (dram_we_n),
      .ba     (dram_ba),
      .addr   (dram_addr)
   );

endmodule

// File: rtl/dcs_chk.sv
`timescale 1ns/1ps
module dcs_chk #(
   parameter int T_RCD = 3,
   parameter int T_RP  = 3
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic cs_n,
   input logic ras_n,
   input logic cas_n,
   input logic we_n
);
   logic [2:0] code;
   logic       is_nop, is_act, is_pre, is_col;
   logic [7:0] since_act, since_pre;

   assign code   = {ras_n, cas_n, we_n};
   assign is_nop = (code == 3'b111);
   assign is_act = (code == 3'b011);
   assign is_pre = (code == 3'b010);
   assign is_col = (code == 3'b101) || (code == 3'b100);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_act <= '0;
         since_pre <= '0;
      end else begin
         if (is_act)
            since_act <= 8'd1;
         else if (since_act != 8'd0 && since_act != 8'hFF)
            since_act <= since_act + 8'd1;
         if (is_pre)
            since_pre <= 8'd1;
         else if (since_pre != 8'd0 && since_pre != 8'hFF)
            since_pre <= since_pre + 8'd1;
      end
   end

   // R2
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n && (is_nop || is_act || is_pre || is_col));

   // R10
   accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !is_nop);

   // R8
   pre_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> !req_ready);

   // R8
   act_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> !req_ready);

   // R7
   col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> !req_ready);

   // R3
   rcd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_col && since_act != 8'd0) |-> (32'(since_act) >= T_RCD));

   // R5
   rp_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && since_pre != 8'd0) |-> (32'(since_pre) >= T_RP));

endmodule

bind dram_cmd_seq dcs_chk #(
   .T_RCD (T_RCD),
   .T_RP  (T_RP)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .cs_n      (dram_cs_n),
   .ras_n     (dram_ras_n),
   .cas_n     (dram_cas_n),
   .we_n      (dram_we_n)
);

// File: tb/dram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_seq_tb_top;
   localparam int T_RCD = 3;
   localparam int T_RP  = 2;
   localparam int NVEC  = 8;

   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_RD  = 4'b0101;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_NOP = 4'b0111;

   // {kind(0 hit,1 closed,2 miss), write, burst8, bank[3], row[14], col[10]}
   localparam logic [30:0] VEC [NVEC] = '{
      {2'd1, 1'b0, 1'b0, 3'd0, 14'd5,     10'd8},
      {2'd0, 1'b1, 1'b0, 3'd0, 14'd5,     10'd16},
      {2'd2, 1'b0, 1'b1, 3'd0, 14'd9,     10'd0},
      {2'd1, 1'b1, 1'b1, 3'd3, 14'd100,   10'd4},
      {2'd0, 1'b0, 1'b0, 3'd3, 14'd100,   10'd12},
      {2'd0, 1'b0, 1'b0, 3'd0, 14'd9,     10'd20},
      {2'd1, 1'b1, 1'b0, 3'd7, 14'd16383, 10'd1023},
      {2'd2, 1'b1, 1'b0, 3'd3, 14'd7,     10'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [2:0]  req_bank = '0;
   logic [13:0] req_row = '0;
   logic [9:0]  req_col = '0;
   logic        cfg_burst8 = 1'b0;
   logic        dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
   logic [2:0]  dram_ba;
   logic [13:0] dram_addr;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int lg_n = 0;
   int          lg_cyc  [256];
   logic [3:0]  lg_op   [256];
   logic [2:0]  lg_ba   [256];
   logic [13:0] lg_addr [256];

   always #2 clk = ~clk;

   dram_cmd_seq #(
      .BANK_W (3),
      .ROW_W  (14),
      .COL_W  (10),
      .T_RCD  (T_RCD),
      .T_RP   (T_RP)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_bank   (req_bank),
      .req_row    (req_row),
      .req_col    (req_col),
      .cfg_burst8 (cfg_burst8),
      .dram_cs_n  (dram_cs_n),
      .dram_ras_n (dram_ras_n),
      .dram_cas_n (dram_cas_n),
      .dram_we_n  (dram_we_n),
      .dram_ba    (dram_ba),
      .dram_addr  (dram_addr)
   );

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (rst_n && {dram_ras_n, dram_cas_n, dram_we_n} != 3'b111 && lg_n < 256) begin
         lg_cyc[lg_n]  = cyc;
         lg_op[lg_n]   = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
         lg_ba[lg_n]   = dram_ba;
         lg_addr[lg_n] = dram_addr;
         lg_n++;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_cmd(input int idx, input logic [3:0] op, input int cy,
                          input int ba, input int addr, input string tcyc);
      if (idx >= lg_n) begin
         check(1'b0, tcyc, "missing command", idx, lg_n);
         return;
      end
      check(lg_op[idx] == op, "R2", "opcode", lg_op[idx], op);
      check(lg_cyc[idx] == cy, tcyc, "issue cycle", lg_cyc[idx], cy);
      check(int'(lg_ba[idx]) == ba, "R6", "bank bus", lg_ba[idx], ba);
      check(int'(lg_addr[idx]) == addr, "R6", "address bus", lg_addr[idx], addr);
   endtask

   task automatic send(input logic wr, input logic b8, input logic [2:0] bank,
                       input logic [13:0] row, input logic [9:0] col, output int e);
      @(negedge clk);
      req_write  = wr;
      cfg_burst8 = b8;
      req_bank   = bank;
      req_row    = row;
      req_col    = col;
      req_valid  = 1'b1;
      while (!req_ready) @(negedge clk);
      e = cyc + 1;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int e, e1, e2, e3, base;
      logic [3:0] colc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      check({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == C_NOP, "R1", "command after reset",
            {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, C_NOP);
      check(dram_addr == '0 && dram_ba == '0, "R1", "buses after reset", dram_addr, 0);

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] kind;
         logic [3:0] cc;
         string tg;
         kind = VEC[i][30:29];
         cc   = VEC[i][28] ? C_WR : C_RD;
         base = lg_n;
         send(VEC[i][28], VEC[i][27], VEC[i][26:24], VEC[i][23:10], VEC[i][9:0], e);
         repeat (12) @(negedge clk);
         tg = (kind == 2'd0) ? "R4" : (kind == 2'd1) ? "R3" : "R5";
         if (i == 5) tg = "R9";
         check(lg_n - base == int'(kind) + 1, tg, "command count", lg_n - base, int'(kind) + 1);
         if (kind == 2'd0) begin
            chk_cmd(base, cc, e, VEC[i][26:24], VEC[i][9:0], tg);
         end else if (kind == 2'd1) begin
            chk_cmd(base, C_ACT, e, VEC[i][26:24], VEC[i][23:10], tg);
            chk_cmd(base + 1, cc, e + T_RCD, VEC[i][26:24], VEC[i][9:0], tg);
         end else begin
            chk_cmd(base, C_PRE, e, VEC[i][26:24], 0, tg);
            chk_cmd(base + 1, C_ACT, e + T_RP, VEC[i][26:24], VEC[i][23:10], tg);
            chk_cmd(base + 2, cc, e + T_RP + T_RCD, VEC[i][26:24], VEC[i][9:0], tg);
         end
      end

      // R8: ready low during precharge and activate waits (bank7 holds row 16383)
      base = lg_n;
      send(1'b0, 1'b0, 3'd7, 14'd1, 10'd3, e);
      @(negedge clk);
      check(req_ready == 1'b0, "R8", "ready in precharge wait", req_ready, 0);
      repeat (T_RP) @(negedge clk);
      check(req_ready == 1'b0, "R8", "ready in activate wait", req_ready, 0);
      repeat (10) @(negedge clk);
      check(req_ready == 1'b1, "R8", "ready after sequence", req_ready, 1);
      chk_cmd(base + 2, C_RD, e + T_RP + T_RCD, 7, 3, "R5");

      // R7 / R10: chained hits on bank0 row 9, burst 8 then burst 4
      base = lg_n;
      send(1'b0, 1'b1, 3'd0, 14'd9, 10'd32, e1);
      send(1'b1, 1'b0, 3'd0, 14'd9, 10'd40, e2);
      send(1'b0, 1'b0, 3'd0, 14'd9, 10'd48, e3);
      repeat (10) @(negedge clk);
      check(e2 - e1 == 4, "R7", "spacing after burst 8", e2 - e1, 4);
      check(e3 - e2 == 2, "R7", "spacing after burst 4", e3 - e2, 2);
      check(lg_n - base == 3, "R10", "one command per held request", lg_n - base, 3);
      chk_cmd(base + 1, C_WR, e2, 0, 40, "R7");
      colc = lg_op[base + 2];
      check(colc == C_RD, "R10", "third command is column", colc, C_RD);

      // R1: reset in mid operation closes all banks
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready after second reset", req_ready, 1);
      base = lg_n;
      send(1'b0, 1'b0, 3'd0, 14'd9, 10'd0, e);
      repeat (10) @(negedge clk);
      check(lg_n - base == 2, "R1", "bank reopened after reset", lg_n - base, 2);
      chk_cmd(base, C_ACT, e, 0, 9, "R1");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule